// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers event pulses from seven peripheral sources (two timers, two control lines on each of two parallel ports, and a shift register) into one flag register. It also holds an enable mask and drives a single active-low interrupt request. Software reaches both registers over an 8-bit bus through one register-select bit.

Each bit of the enable register is set or cleared by a single write. Bit 7 of the written byte picks the direction, so software never needs a read-modify-write. A flag is recorded whether or not its source is enabled. Bit 7 of a flag read summarises whether any enabled flag is pending. Each source also has a clear input, so the logic that decodes the source's own data register can drop its flag as a read side effect.

Top module: `irq_flag_ctrl`

## Requirements
- R1: Bit i of the flag register and of the enable register belongs to srcSet[i] / srcRdClr[i]. The assignment is: bit 6 timer 1, bit 5 timer 2, bit 4 port-B line 1, bit 3 port-B line 2, bit 2 shift register, bit 1 port-A line 1, bit 0 port-A line 2.
- R2: An enable write (busSel=1, busWrite=1, busRegSel=1) with busWdata[7]=1 sets every enable whose written bit is 1. Enables written as 0 keep their value.
- R3: An enable write with busWdata[7]=0 clears every enable whose written bit is 1. Enables written as 0 keep their value.
- R4: With busRegSel=1, busRdata returns {1'b0, enables[6:0]}.
- R5: A srcSet pulse sets its flag on the next clock edge, whatever the state of its enable.
- R6: With busRegSel=0, busRdata returns {summary, flags[6:0]}. The summary is 1 exactly when some flag is set and its enable is 1.
- R7: A flag write (busSel=1, busWrite=1, busRegSel=0) clears each flag whose written bit is 0. Flags written as 1 are unchanged, and busWdata[7] has no effect.
- R8: irqN is a register. After each clock edge it equals the inverse of "some flag set and enabled" as that held just before the edge, so it follows a flag or enable change one clock later.
- R9: While rstN is low, all flags and enables are 0 and irqN is 1.
- R10: When a flag's srcSet pulse falls in the same cycle as a clear from a flag write or from srcRdClr, the flag ends up set.
- R11: srcRdClr[i] high at a clock edge clears flag i, unless R10 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access strobe for this block |
| busWrite | input | 1 | 1 = write, 0 = read |
| busRegSel | input | 1 | 0 = flag register, 1 = enable register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Contents of the selected register; reading has no side effect |
| srcSet | input | 7 | One-cycle event pulses, one per source |
| srcRdClr | input | 7 | Per-source flag clear from the source's own register read |
| irqN | output | 1 | Registered active-low interrupt request |

## Verification
A flag's set pulse can land in the same cycle as a clear for that flag. The clear can come from a flag-register write with a 0 in that position, or from the source's read-clear input. The bench provokes both cases with directed cycles and then with a long random run. It drives sparse set pulses together with random flag writes and read-clears, and expects the flag to survive. Every cycle, the request line and the selected register are judged against a behavioural model in which the set is applied after all clears.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef struct packed {
    logic flagWr;
    logic enWr;
    logic enSetMode;
    logic showEn;
  } irqcStrobes_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic         busSel,
  input  logic         busWrite,
  input  logic         busRegSel,
  input  logic         modeBit,
  output irqcStrobes_t strb
);
  logic wrAccess;
  assign wrAccess = busSel & busWrite;

  always_comb begin
    strb.flagWr    = wrAccess & ~busRegSel;
    strb.enWr      = wrAccess & busRegSel;
    strb.enSetMode = modeBit;
    strb.showEn    = busRegSel;
  end
endmodule

// File: rtl/irqc_flag_cell.sv
module irqc_flag_cell (
  input  logic clk,
  input  logic rstN,
  input  logic setPulse,
  input  logic clrReq,
  output logic flagQ
);
  // the set term is applied after the clear, so an event is never lost
  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= 1'b0;
    else       flagQ <= setPulse | (flagQ & ~clrReq);
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 7,
  localparam int DATA_W = NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqcStrobes_t       strb,
  input  logic [NUM_SRC-1:0] wrBits,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic [NUM_SRC-1:0] srcRdClr,
  output logic [NUM_SRC-1:0] flagVec,
  output logic [NUM_SRC-1:0] enVec,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqN
);
  logic [NUM_SRC-1:0] clrVec;
  logic [NUM_SRC-1:0] enNext;
  logic               pending;
  logic               irqAct;

  assign clrVec = (strb.flagWr ? ~wrBits : {NUM_SRC{1'b0}}) | srcRdClr;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    irqc_flag_cell u_cell (
      .clk      (clk),
      .rstN     (rstN),
      .setPulse (srcSet[i]),
      .clrReq   (clrVec[i]),
      .flagQ    (flagVec[i])
    );
  end

  always_comb begin
    enNext = enVec;
    if (strb.enWr) begin
      if (strb.enSetMode) enNext = enVec | wrBits;
      else                enNext = enVec & ~wrBits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) enVec <= '0;
    else       enVec <= enNext;
  end

  assign pending = |(flagVec & enVec);

  always_ff @(posedge clk) begin
    if (!rstN) irqAct <= 1'b0;
    else       irqAct <= pending;
  end

  assign irqN   = ~irqAct;
  assign rdData = strb.showEn ? {1'b0, enVec} : {pending, flagVec};
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 7,
  localparam int DATA_W = NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic               busRegSel,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic [NUM_SRC-1:0] srcRdClr,
  output logic               irqN
);
  irqcStrobes_t       strb;
  logic [NUM_SRC-1:0] flagVec;
  logic [NUM_SRC-1:0] enVec;

  irqc_ctrl u_ctrl (
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busRegSel (busRegSel),
    .modeBit   (busWdata[DATA_W-1]),
    .strb      (strb)
  );

  irqc_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrBits   (busWdata[NUM_SRC-1:0]),
    .srcSet   (srcSet),
    .srcRdClr (srcRdClr),
    .flagVec  (flagVec),
    .enVec    (enVec),
    .rdData   (busRdata),
    .irqN     (irqN)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC = 7,
  localparam int DATA_W = NUM_SRC + 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWrite,
  input logic               busRegSel,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic [NUM_SRC-1:0] srcSet,
  input logic [NUM_SRC-1:0] srcRdClr,
  input logic               irqN,
  input logic [NUM_SRC-1:0] flagVec,
  input logic [NUM_SRC-1:0] enVec
);
  logic wrFlag;
  logic wrEn;
  assign wrFlag = busSel && busWrite && !busRegSel;
  assign wrEn   = busSel && busWrite && busRegSel;

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (srcSet != '0) |=> ((flagVec & $past(srcSet)) == $past(srcSet)));

  p_irq_delay_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (irqN == !$past(|(flagVec & enVec))));

  p_en_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busWdata[DATA_W-1]) |=> (enVec == ($past(enVec) | $past(busWdata[NUM_SRC-1:0]))));

  p_en_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busWdata[DATA_W-1]) |=> (enVec == ($past(enVec) & ~$past(busWdata[NUM_SRC-1:0]))));

  p_en_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    busRegSel |-> (busRdata == {1'b0, enVec}));

  p_summary_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busRegSel |-> (busRdata[DATA_W-1] == |(flagVec & enVec)));

  p_flag_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrFlag && srcSet == '0 && srcRdClr == '0)
      |=> (flagVec == ($past(flagVec) & $past(busWdata[NUM_SRC-1:0]))));

  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!wrFlag && srcSet == '0 && srcRdClr == '0) |=> $stable(flagVec));

  p_read_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (srcRdClr != '0 && srcSet == '0) |=> ((flagVec & $past(srcRdClr)) == '0));
endmodule

bind irq_flag_ctrl irqc_checker #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/irq_flag_ctrl_test.sv
module irq_flag_ctrl_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWrite = 1'b0;
  logic       busRegSel = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic [6:0] srcSet = 7'h00;
  logic [6:0] srcRdClr = 7'h00;
  logic       irqN;

  int nRun = 0;
  int nFail = 0;
  int mFlags = 0;
  int mEn = 0;
  int mIrq = 0;

  always #2.5 clk = ~clk;

  irq_flag_ctrl uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busRegSel(busRegSel), .busWdata(busWdata), .busRdata(busRdata),
    .srcSet(srcSet), .srcRdClr(srcRdClr), .irqN(irqN)
  );

  // behavioural reference: clears first, then sets, request from old state
  always @(posedge clk) begin
    int nf;
    int ne;
    int bits;
    if (!rstN) begin
      mFlags = 0; mEn = 0; mIrq = 0;
    end else begin
      mIrq = ((mFlags & mEn) != 0) ? 1 : 0;
      bits = int'(busWdata) & 'h7f;
      nf = mFlags;
      if (busSel && busWrite && !busRegSel) nf = nf & bits;
      nf = nf & ~int'(srcRdClr);
      nf = nf | int'(srcSet);
      ne = mEn;
      if (busSel && busWrite && busRegSel) ne = busWdata[7] ? (ne | bits) : (ne & ~bits);
      mFlags = nf;
      mEn = ne;
    end
  end

  task automatic expectVal(string tag, logic [7:0] act, logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic compareModel(string tag);
    int expRd;
    expRd = busRegSel ? mEn : ((((mFlags & mEn) != 0) ? 128 : 0) | mFlags);
    expectVal(tag, busRdata, 8'(expRd));
    expectVal("R8 irqN", {7'b0, irqN}, {7'b0, (mIrq == 0)});
  endtask

  task automatic cyc(string tag, logic s, logic w, logic rs, logic [7:0] wd,
                     logic [6:0] st, logic [6:0] cl);
    busSel = s; busWrite = w; busRegSel = rs; busWdata = wd;
    srcSet = st; srcRdClr = cl;
    @(negedge clk);
    compareModel(tag);
  endtask

  task automatic idle(string tag, logic rs);
    cyc(tag, 1'b0, 1'b0, rs, 8'h00, 7'h00, 7'h00);
  endtask

  initial begin
    #(200000 * 5.0);
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    busRegSel = 1'b0; #0.1;
    expectVal("R9 flags in reset", busRdata, 8'h00);
    busRegSel = 1'b1; #0.1;
    expectVal("R9 enables in reset", busRdata, 8'h00);
    expectVal("R9 irqN in reset", {7'b0, irqN}, 8'h01);
    @(negedge clk);
    rstN = 1'b1;
    idle("R9", 1'b0);

    // R1 / R5 / R7: each source lands on its own bit while disabled
    for (int i = 0; i < 7; i++) begin
      cyc("R5", 1'b0, 1'b0, 1'b0, 8'h00, 7'(1 << i), 7'h00);
      expectVal("R1 bit position", busRdata, 8'(1 << i));
      cyc("R7", 1'b1, 1'b1, 1'b0, 8'hFF ^ 8'(1 << i), 7'h00, 7'h00);
      expectVal("R7 write-zero clears", busRdata, 8'h00);
    end

    // R2 / R3 / R4 enable set and clear
    cyc("R2", 1'b1, 1'b1, 1'b1, 8'hC4, 7'h00, 7'h00);
    expectVal("R2 set enables", busRdata, 8'h44);
    cyc("R2", 1'b1, 1'b1, 1'b1, 8'hA2, 7'h00, 7'h00);
    expectVal("R2 keep others", busRdata, 8'h66);
    cyc("R3", 1'b1, 1'b1, 1'b1, 8'h24, 7'h00, 7'h00);
    expectVal("R3 clear enables", busRdata, 8'h42);
    expectVal("R4 bit7 zero", {7'b0, busRdata[7]}, 8'h00);

    // R5 disabled flag gives no request
    cyc("R5", 1'b0, 1'b0, 1'b0, 8'h00, 7'h20, 7'h00);
    expectVal("R5 disabled flag visible", busRdata, 8'h20);
    idle("R8", 1'b0);
    expectVal("R8 no request for disabled", {7'b0, irqN}, 8'h01);

    // R6 / R8 enabled flag: summary now, request one clock later
    cyc("R6", 1'b0, 1'b0, 1'b0, 8'h00, 7'h02, 7'h00);
    expectVal("R6 summary", busRdata, 8'hA2);
    expectVal("R8 not yet", {7'b0, irqN}, 8'h01);
    idle("R8", 1'b0);
    expectVal("R8 asserted", {7'b0, irqN}, 8'h00);

    // R7 all-ones writes change nothing, bit 7 ignored
    cyc("R7", 1'b1, 1'b1, 1'b0, 8'hFF, 7'h00, 7'h00);
    expectVal("R7 ones keep", busRdata, 8'hA2);
    cyc("R7", 1'b1, 1'b1, 1'b0, 8'h7F, 7'h00, 7'h00);
    expectVal("R7 bit7 ignored", busRdata, 8'hA2);

    // R10 set beats flag-write clear
    cyc("R10", 1'b1, 1'b1, 1'b0, 8'h00, 7'h02, 7'h00);
    expectVal("R10 set wins write", busRdata, 8'h82);
    // R11 read-clear, and R10 against read-clear
    cyc("R11", 1'b0, 1'b0, 1'b0, 8'h00, 7'h10, 7'h12);
    expectVal("R11 read clear / R10 set wins", busRdata, 8'h10);
    idle("R8", 1'b0);
    expectVal("R8 deasserted", {7'b0, irqN}, 8'h01);

    // R8 disabling the enable drops the request a clock later
    cyc("R8", 1'b1, 1'b1, 1'b1, 8'h90, 7'h00, 7'h00);
    idle("R8", 1'b0);
    expectVal("R8 asserted by enable", {7'b0, irqN}, 8'h00);
    cyc("R3", 1'b1, 1'b1, 1'b1, 8'h10, 7'h00, 7'h00);
    expectVal("R8 still registered", {7'b0, irqN}, 8'h00);
    idle("R8", 1'b0);
    expectVal("R8 dropped", {7'b0, irqN}, 8'h01);

    // random run against the model (R10 collisions included)
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] st;
      st = (($urandom % 4) == 0) ? 7'($urandom) : 7'h00;
      cyc("R10 random", 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
          st, (($urandom % 3) == 0) ? 7'($urandom) : 7'h00);
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule